// File: doc/BRIEF.md
# Multi-Policy Message Slot Buffer

This block sits between a slow word-serial writer (a command/response bus terminal that hands over 16-bit words) and a fast reader (a packet-network side that drains whole messages). Storage is one inferred RAM. It is carved into slots of 32 words, and each slot holds exactly one message. The writer streams words and marks the final word of a message with an end strobe. The block keeps the committed length beside the slot, so short messages are read back at their true length.

A two-bit policy input selects how slots are handed out:
- **Fixed policy:** each message type owns one slot, and a newer message replaces an unread older one.
- **Ping-pong policy:** the slots form two equal halves. The writer fills one half while the reader empties the other, and the halves swap once the writer has filled its half.
- **Ring policy:** messages go into consecutive slots and the write position wraps around. When the writer reaches an unread slot, the oldest message is dropped.

Loss-free transfer holds only while the reader keeps ahead of the writer. The overflow output reports where this was not the case.

The reader asks for a message with a one-cycle start pulse. The block then returns one word per cycle, starting on the cycle after the pulse is taken, and marks the final word.

Top module: `msg_slot_buffer`

## Requirements
- R1: After reset the buffer is empty, no message is available, overflow is low, the policy is fixed (code 0), the used-slot count is 0 and no read word is valid.
- R2: A word taken together with the end strobe commits the message at its written length of 1 to 32 words. A start pulse taken while a message is available returns that message's words in order, one per cycle, beginning on the cycle after the pulse. The last-word marker is high on the final word only.
- R3: A 32nd word written without an end strobe closes the message anyway, and the next word begins a new message.
- R4: Under the fixed policy (code 0) the type tag is the slot index. A message of a tag whose slot is still unread replaces the older one without raising the used count. Messages are read in ascending slot order.
- R5: Under the ping-pong policy (code 1), slots 0 to N/2-1 form one half and the rest form the other half, with writing starting in the lower half. The reader sees only the half not being written. The halves swap when the writer commits the last slot of its half and the other half is fully drained. The reader reads its half in ascending slot order.
- R6: Under the ping-pong policy, a swap refused because the other half still holds unread data sets the sticky overflow flag. Later messages then rewrite the last slot of the writer's half, and unread messages in the reader's half stay intact.
- R7: Under the ring policy (code 2) messages are read in the order they were written, across wrap-around of the slot index.
- R8: Under the ring policy, committing into an unread slot sets the sticky overflow flag and drops the oldest message. The reader continues from the oldest surviving message.
- R9: A new policy code takes effect only when the buffer is empty, with no stored message, no read in progress and no partial message. Code 3 is never accepted. Taking a new policy clears all slots, pointers and the overflow flag.
- R10: A start pulse given while no message is available, or while a message is being read out, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Requested policy: 0 fixed, 1 ping-pong, 2 ring, 3 reserved |
| wr_valid | input | 1 | Write word valid |
| wr_data | input | WORD_W | Write word |
| wr_end | input | 1 | Current word is the last of its message |
| wr_tag | input | log2(NUM_SLOTS) | Message type, used as the slot index under the fixed policy |
| rd_start | input | 1 | Request to read out the next available message |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | WORD_W | Read word |
| rd_last | output | 1 | Read word is the last of its message |
| msg_avail | output | 1 | A message can be started now |
| buf_empty | output | 1 | No stored, partial or in-flight message |
| overflow | output | 1 | Sticky loss indication |
| mode_now | output | 2 | Policy in force |
| slots_used | output | log2(NUM_SLOTS)+1 | Count of committed, unread slots |

## Verification
The assertions assume that a policy request never coincides with a write word. They also assume that, under the fixed policy, no write targets the slot being read, and that ring overruns never overlap a read in progress. The stimulus keeps to these rules: writes and reads are issued strictly one after the other from a single sequence, and policy codes are changed only between messages. Random message lengths and batch sizes under the ring policy drive the write index through several wraps. Directed sequences force the refused ping-pong swap and the ring overrun.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;
  localparam logic [1:0] POL_FIXED    = 2'd0;
  localparam logic [1:0] POL_PINGPONG = 2'd1;
  localparam logic [1:0] POL_RING     = 2'd2;
  localparam logic [1:0] POL_RSVD     = 2'd3;

  function automatic logic policy_legal(input logic [1:0] code);
    return code != POL_RSVD;
  endfunction
endpackage

// File: rtl/msgbuf_ram.sv
module msgbuf_ram #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 512,
  parameter int AW     = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/msgbuf_alloc.sv
module msgbuf_alloc
  import msgbuf_pkg::*;
#(
  parameter int SLOT_WORDS = 32,
  parameter int NUM_SLOTS  = 16,
  parameter int SW_W       = 5,
  parameter int SI_W       = 4,
  parameter int LEN_W      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_sel,
  input  logic                 wr_valid,
  input  logic                 wr_end,
  input  logic [SI_W-1:0]      wr_tag,
  input  logic                 claim,
  input  logic                 rd_busy,
  input  logic [SI_W-1:0]      rd_slot,
  output logic                 we,
  output logic [SI_W+SW_W-1:0] waddr,
  output logic                 cand_ok,
  output logic [SI_W-1:0]      cand_slot,
  output logic [LEN_W-1:0]     cand_len,
  output logic [1:0]           mode_now,
  output logic                 buf_empty,
  output logic                 overflow,
  output logic [SI_W:0]        slots_used
);
  localparam int HALF = NUM_SLOTS / 2;

  logic [1:0]           mode_q;
  logic [NUM_SLOTS-1:0] full_q;
  logic [LEN_W-1:0]     len_q [NUM_SLOTS];
  logic [SI_W-1:0]      wptr_q, rptr_q;
  logic [SW_W-1:0]      wcnt_q;
  logic                 ovf_q;

  // slot arithmetic kept in functions so the bench can restate it
  function automatic logic half_of(input logic [SI_W-1:0] s);
    return s[SI_W-1];
  endfunction

  function automatic logic half_end(input logic [SI_W-1:0] s);
    return &s[SI_W-2:0];
  endfunction

  function automatic logic [NUM_SLOTS-1:0] half_mask(input logic h);
    logic [NUM_SLOTS-1:0] m;
    for (int i = 0; i < NUM_SLOTS; i++) m[i] = ((i >= HALF) == h);
    return m;
  endfunction

  function automatic logic [SI_W-1:0] first_set(input logic [NUM_SLOTS-1:0] v);
    logic [SI_W-1:0] r;
    r = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) if (v[i]) r = SI_W'(i);
    return r;
  endfunction

  // named internal events
  logic                 empty_w, mode_apply, write_ok, commit;
  logic                 other_clear, ring_hit, swap_refused;
  logic [SI_W-1:0]      wslot;
  logic [NUM_SLOTS-1:0] read_mask;

  always_comb begin
    empty_w     = (full_q == '0) && !rd_busy && (wcnt_q == '0);
    mode_apply  = (mode_sel != mode_q) && policy_legal(mode_sel) && empty_w;
    write_ok    = wr_valid && !mode_apply;
    commit      = write_ok && (wr_end || wcnt_q == SW_W'(SLOT_WORDS - 1));
    wslot       = (mode_q == POL_FIXED) ? wr_tag : wptr_q;
    other_clear = ((full_q & half_mask(!half_of(wptr_q))) == '0) && !rd_busy;
    ring_hit    = full_q[wptr_q];
    swap_refused = (mode_q == POL_PINGPONG) && commit && half_end(wptr_q) && !other_clear;
    read_mask   = '0;
    case (mode_q)
      POL_PINGPONG: read_mask = full_q & half_mask(!half_of(wptr_q));
      POL_RING:     read_mask[rptr_q] = full_q[rptr_q];
      default:      read_mask = full_q;
    endcase
  end

  assign we         = write_ok;
  assign waddr      = {wslot, wcnt_q};
  assign cand_ok    = (read_mask != '0) && !rd_busy;
  assign cand_slot  = first_set(read_mask);
  assign cand_len   = len_q[cand_slot];
  assign mode_now   = mode_q;
  assign buf_empty  = empty_w;
  assign overflow   = ovf_q;
  assign slots_used = (SI_W+1)'($countones(full_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= POL_FIXED;
      full_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      wcnt_q <= '0;
      ovf_q  <= 1'b0;
    end else if (mode_apply) begin
      mode_q <= mode_sel;
      full_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
      wcnt_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (claim) begin
        full_q[cand_slot] <= 1'b0;
        if (mode_q == POL_RING) rptr_q <= cand_slot + 1'b1;
      end
      if (write_ok) wcnt_q <= commit ? '0 : wcnt_q + 1'b1;
      if (commit) begin
        full_q[wslot] <= 1'b1;
        case (mode_q)
          POL_PINGPONG: begin
            if (half_end(wptr_q)) begin
              if (other_clear) wptr_q <= half_of(wptr_q) ? '0 : SI_W'(HALF);
              else             ovf_q  <= 1'b1;
            end else begin
              wptr_q <= wptr_q + 1'b1;
            end
          end
          POL_RING: begin
            wptr_q <= wptr_q + 1'b1;
            if (ring_hit) begin
              ovf_q  <= 1'b1;
              rptr_q <= wptr_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) len_q[wslot] <= LEN_W'(wcnt_q) + LEN_W'(1);
  end

  // overflow stays set until a new policy is taken (R6, R8)
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !mode_apply |=> ovf_q);

  // policy changes only from an empty buffer (R9)
  assert_mode_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(empty_w));

  // reader and writer never share a half under ping-pong (R5)
  assert_halves_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == POL_PINGPONG) && rd_busy |-> half_of(rd_slot) != half_of(wptr_q));

  // a refused swap leaves the writer in its own half (R6)
  assert_refused_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swap_refused && !claim |=> $stable(wptr_q) && ovf_q);
endmodule

// File: rtl/msgbuf_reader.sv
module msgbuf_reader #(
  parameter int SW_W  = 5,
  parameter int SI_W  = 4,
  parameter int LEN_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_start,
  input  logic                 cand_ok,
  input  logic [SI_W-1:0]      cand_slot,
  input  logic [LEN_W-1:0]     cand_len,
  output logic                 claim,
  output logic                 busy,
  output logic [SI_W-1:0]      slot,
  output logic [SI_W+SW_W-1:0] raddr,
  output logic                 rd_valid,
  output logic                 rd_last
);
  logic             busy_q, valid_q, last_q;
  logic [SI_W-1:0]  slot_q;
  logic [SW_W-1:0]  cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             final_word;

  assign claim      = rd_start && cand_ok;
  assign final_word = (LEN_W'(cnt_q) + LEN_W'(1)) == len_q;
  assign raddr      = {slot_q, cnt_q};
  assign busy       = busy_q;
  assign slot       = slot_q;
  assign rd_valid   = valid_q;
  assign rd_last    = last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      slot_q  <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      valid_q <= busy_q;
      last_q  <= busy_q && final_word;
      if (claim) begin
        busy_q <= 1'b1;
        slot_q <= cand_slot;
        len_q  <= cand_len;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (final_word) busy_q <= 1'b0;
      end
    end
  end

  // the marker only ever accompanies a word (R2)
  assert_last_with_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> valid_q);

  // words of one message arrive back to back (R2)
  assert_gapless_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !last_q |=> valid_q);

  // a start pulse during readout does not restart it (R10)
  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !final_word |=> busy_q && $stable(slot_q));
endmodule

// File: rtl/msg_slot_buffer.sv
module msg_slot_buffer
  import msgbuf_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int SLOT_WORDS = 32,
  parameter int NUM_SLOTS  = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   mode_sel,
  input  logic                         wr_valid,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic                         wr_end,
  input  logic [$clog2(NUM_SLOTS)-1:0] wr_tag,
  input  logic                         rd_start,
  output logic                         rd_valid,
  output logic [WORD_W-1:0]            rd_data,
  output logic                         rd_last,
  output logic                         msg_avail,
  output logic                         buf_empty,
  output logic                         overflow,
  output logic [1:0]                   mode_now,
  output logic [$clog2(NUM_SLOTS):0]   slots_used
);
  localparam int SW_W  = $clog2(SLOT_WORDS);
  localparam int SI_W  = $clog2(NUM_SLOTS);
  localparam int LEN_W = SW_W + 1;
  localparam int DEPTH = NUM_SLOTS * SLOT_WORDS;
  localparam int AW    = SI_W + SW_W;

  logic            we, claim, rd_busy, cand_ok;
  logic [AW-1:0]   waddr, raddr;
  logic [SI_W-1:0] cand_slot, rd_slot;
  logic [LEN_W-1:0] cand_len;

  msgbuf_alloc #(
    .SLOT_WORDS(SLOT_WORDS), .NUM_SLOTS(NUM_SLOTS),
    .SW_W(SW_W), .SI_W(SI_W), .LEN_W(LEN_W)
  ) u_alloc (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .wr_valid(wr_valid), .wr_end(wr_end), .wr_tag(wr_tag),
    .claim(claim), .rd_busy(rd_busy), .rd_slot(rd_slot),
    .we(we), .waddr(waddr),
    .cand_ok(cand_ok), .cand_slot(cand_slot), .cand_len(cand_len),
    .mode_now(mode_now), .buf_empty(buf_empty), .overflow(overflow),
    .slots_used(slots_used)
  );

  msgbuf_reader #(.SW_W(SW_W), .SI_W(SI_W), .LEN_W(LEN_W)) u_reader (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start),
    .cand_ok(cand_ok), .cand_slot(cand_slot), .cand_len(cand_len),
    .claim(claim), .busy(rd_busy), .slot(rd_slot), .raddr(raddr),
    .rd_valid(rd_valid), .rd_last(rd_last)
  );

  msgbuf_ram #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );

  assign msg_avail = cand_ok;

  // a message is offered only while something is stored (R1, R10)
  assert_avail_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_avail |-> slots_used != '0);
endmodule

// File: tb/test_msg_slot_buffer.sv
`timescale 1ns/1ps
module test_msg_slot_buffer;
  localparam int NS = 16;

  logic        clk = 0, rst_n = 0;
  logic [1:0]  mode_sel = 0;
  logic        wr_valid = 0, wr_end = 0, rd_start = 0;
  logic [15:0] wr_data = 0;
  logic [3:0]  wr_tag = 0;
  logic        rd_valid, rd_last, msg_avail, buf_empty, overflow;
  logic [15:0] rd_data;
  logic [1:0]  mode_now;
  logic [4:0]  slots_used;
  int checks = 0, errors = 0;

  msg_slot_buffer i_msg_slot_buffer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_end(wr_end), .wr_tag(wr_tag), .rd_start(rd_start),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .msg_avail(msg_avail), .buf_empty(buf_empty), .overflow(overflow),
    .mode_now(mode_now), .slots_used(slots_used)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] pat(input int id, input int i);
    return {8'(id), 8'(i)} ^ 16'hA5C3;
  endfunction

  function automatic int pp_len(input int id);
    return 2 + (id % 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_msg(input int tag, input int id, input int len, input bit strobe);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wr_valid = 1; wr_tag = 4'(tag); wr_data = pat(id, i);
      wr_end = strobe && (i == len - 1);
    end
    @(negedge clk);
    wr_valid = 0; wr_end = 0;
  endtask

  task automatic read_msg(input int id, input int len, input string req);
    int bad = 0;
    @(negedge clk);
    if (!msg_avail) bad += 100;
    rd_start = 1;
    @(negedge clk);
    rd_start = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (!rd_valid || rd_data != pat(id, i) || rd_last != (i == len - 1)) bad++;
    end
    @(negedge clk);
    if (rd_valid) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode_sel = m;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nid, k;
    int lens[4];
    void'($urandom(32'd20161));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(buf_empty == 1, "R1 empty", buf_empty, 1);
    chk(msg_avail == 0, "R1 avail", msg_avail, 0);
    chk(overflow == 0, "R1 overflow", overflow, 0);
    chk(mode_now == 0, "R1 mode", mode_now, 0);
    chk(slots_used == 0 && rd_valid == 0, "R1 used/valid", slots_used, 0);

    // R10 start pulse with nothing stored
    @(negedge clk); rd_start = 1;
    @(negedge clk); rd_start = 0;
    @(negedge clk);
    chk(rd_valid == 0, "R10 no read when empty", rd_valid, 0);

    // R4 fixed slots with replacement, ascending order
    send_msg(3, 1, 5, 1);
    send_msg(1, 2, 32, 1);
    send_msg(3, 3, 2, 1);
    chk(slots_used == 2, "R4 replace keeps count", slots_used, 2);
    read_msg(2, 32, "R4 lowest tag first");
    read_msg(3, 2, "R4 newest replaces older");
    send_msg(5, 4, 1, 1);
    read_msg(4, 1, "R2 single word message");
    chk(buf_empty == 1, "R2 empty after reads", buf_empty, 1);

    // R3 implicit close at 32 words
    send_msg(0, 5, 32, 0);
    chk(msg_avail == 1, "R3 closed without strobe", msg_avail, 1);
    read_msg(5, 32, "R3 full slot read");
    chk(buf_empty == 1, "R3 no partial left", buf_empty, 1);

    // R9 policy selection
    set_mode(2'd3);
    chk(mode_now == 0, "R9 code 3 refused", mode_now, 0);
    set_mode(2'd2);
    chk(mode_now == 2, "R9 ring taken", mode_now, 2);
    send_msg(0, 6, 4, 1);
    set_mode(2'd0);
    chk(mode_now == 2, "R9 held while not empty", mode_now, 2);
    read_msg(6, 4, "R9 message kept");
    @(negedge clk);
    chk(mode_now == 0, "R9 taken once empty", mode_now, 0);
    set_mode(2'd2);

    // R7 random ring batches
    nid = 10;
    for (int it = 0; it < 40; it++) begin
      k = 1 + int'($urandom % 4);
      for (int j = 0; j < k; j++) begin
        lens[j] = 1 + int'($urandom % 32);
        send_msg(0, nid + j, lens[j], 1);
      end
      for (int j = 0; j < k; j++) read_msg(nid + j, lens[j], "R7 ring order");
      nid += k;
    end

    // R8 ring overrun drops oldest
    for (int i = 0; i < NS + 3; i++) send_msg(0, 200 + i, 3, 1);
    chk(overflow == 1, "R8 overflow set", overflow, 1);
    chk(slots_used == NS, "R8 all slots used", slots_used, NS);
    for (int i = 3; i < NS + 3; i++) read_msg(200 + i, 3, "R8 oldest dropped");
    chk(overflow == 1, "R8 overflow sticky", overflow, 1);

    // R9 new policy clears overflow
    set_mode(2'd1);
    chk(mode_now == 1 && overflow == 0, "R9 pingpong clears flag", overflow, 0);

    // R5 / R6 ping-pong
    for (int id = 20; id < 23; id++) send_msg(0, id, pp_len(id), 1);
    chk(msg_avail == 0, "R5 writer half hidden", msg_avail, 0);
    for (int id = 23; id < 28; id++) send_msg(0, id, pp_len(id), 1);
    chk(msg_avail == 1, "R5 swap after full half", msg_avail, 1);
    read_msg(20, pp_len(20), "R5 first of half");
    read_msg(21, pp_len(21), "R5 second of half");
    for (int id = 28; id < 36; id++) send_msg(0, id, pp_len(id), 1);
    chk(overflow == 1, "R6 refused swap flags", overflow, 1);
    send_msg(0, 36, pp_len(36), 1);
    send_msg(0, 37, pp_len(37), 1);
    chk(slots_used == 14, "R6 last slot rewritten", slots_used, 14);
    for (int id = 22; id < 28; id++) read_msg(id, pp_len(id), "R6 unread half intact");
    chk(msg_avail == 0, "R5 no swap without commit", msg_avail, 0);
    send_msg(0, 38, pp_len(38), 1);
    for (int id = 28; id < 35; id++) read_msg(id, pp_len(id), "R5 swapped half");
    read_msg(38, pp_len(38), "R6 final rewrite wins");
    chk(buf_empty == 1, "R5 drained", buf_empty, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule